// File: doc/BRIEF.md
# Ladder Instruction-List Boolean Processor

This block evaluates ladder logic written as an instruction list. One instruction is accepted per clock. Each instruction holds a 5-bit opcode, a 2-bit device type and a bit index. The block keeps one running logic result, called the accumulator. Load, series and parallel contacts fold a bit from a small device memory into that result. The memory holds input, output, internal-relay and step-relay bits.

Sub-circuits are combined through a block stack. Outputs that share one condition are driven from a separate branch stack. Contacts can also be qualified by an edge: a rising or falling edge is judged against the operand's value in the previous scan. An end-of-program instruction closes the scan. It latches the current device image for the next edge comparison, clears both stacks and pulses a done flag.

Illegal stack usage raises sticky error flags that software can observe at the end of a scan. The flags clear when the next scan begins. The block is meant to sit behind an instruction fetcher that streams a program one instruction per cycle.

Top module: `lbp_core`

## Requirements
- R1: A load (LD=1) sets the accumulator to the operand, and a load-inverted (LDI=2) sets it to the operand's complement. If a result is in progress (any logic instruction issued since the last coil write or end of scan), that result is pushed onto the block stack first.
- R2: Series contacts AND the accumulator with the operand (AND=3) or with its complement (ANI=4). Parallel contacts OR the accumulator with the operand (OR=5) or with its complement (ORI=6).
- R3: The edge variants contribute a 1 only on a rising edge (LDP=7, ANDP=9, ORP=11) or a falling edge (LDF=8, ANDF=10, ORF=12). An edge is judged between the operand now and its image captured at the last end-of-program instruction.
- R4: Block-series (ANB=13) ANDs the accumulator with a value popped from the block stack, and block-parallel (ORB=14) ORs it with the popped value.
- R5: Branch-store (MPS=15) saves the accumulator. Branch-read (MRD=16) copies the saved top into the accumulator and keeps it. Branch-pop (MPP=17) copies the top and removes it.
- R6: Up to 8 branch-store entries may be outstanding. A ninth sets the overflow flag ovf_o.
- R7: Eight consecutive block-series instructions are legal. A ninth consecutive one sets ovf_o.
- R8: The coil instruction (OUT=18) writes the accumulator into the addressed bit. Device codes are 0 input, 1 output, 2 internal, 3 step. A coil write to an input has no effect.
- R9: The inverse instruction (INV=19) complements the accumulator.
- R10: ANB, ORB, MRD or MPP on an empty stack sets the sticky underflow flag unf_o and leaves the accumulator unchanged. Both error flags clear only on reset or when the first instruction of a new scan is accepted.
- R11: The end instruction (END=20) raises done_o for exactly one cycle, empties both stacks and ends the scan. Opcode 0 is a no-operation.
- R12: After reset, the accumulator, all output, internal and step bits, done_o and both error flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Instruction offered this cycle |
| in_ready_o | output | 1 | Instruction accepted (always high) |
| in_op_i | input | 5 | Opcode |
| in_dev_i | input | 2 | Operand device type |
| in_idx_i | input | IDX_W | Operand bit index |
| x_i | input | NBITS | Physical input bits |
| y_o | output | NBITS | Output bits |
| m_o | output | NBITS | Internal relay bits |
| s_o | output | NBITS | Step relay bits |
| acc_o | output | 1 | Current logic result |
| done_o | output | 1 | One-cycle pulse after end of scan |
| ovf_o | output | 1 | Sticky stack-depth overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The assertions assume that opcodes stay within the defined range, that the input bits only change between scans, and that in_valid_i never carries an undefined value while out of reset. The bench drives each instruction at the falling clock edge, one per cycle, and changes x_i only after an end instruction. It uses only the listed opcode and device codes. The checks on edge contacts therefore compare against an input image the bench itself controls.

// File: rtl/lbp_pkg.sv
// Shared encodings for the ladder boolean processor.
// Assumes opcode values above OP_END are never issued.
package lbp_pkg;
    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,  OP_LD   = 5'd1,  OP_LDI  = 5'd2,  OP_AND  = 5'd3,
        OP_ANI  = 5'd4,  OP_OR   = 5'd5,  OP_ORI  = 5'd6,  OP_LDP  = 5'd7,
        OP_LDF  = 5'd8,  OP_ANDP = 5'd9,  OP_ANDF = 5'd10, OP_ORP  = 5'd11,
        OP_ORF  = 5'd12, OP_ANB  = 5'd13, OP_ORB  = 5'd14, OP_MPS  = 5'd15,
        OP_MRD  = 5'd16, OP_MPP  = 5'd17, OP_OUT  = 5'd18, OP_INV  = 5'd19,
        OP_END  = 5'd20
    } lbp_op_e;

    typedef enum logic [1:0] {
        DEV_IN   = 2'd0,
        DEV_OUT  = 2'd1,
        DEV_INT  = 2'd2,
        DEV_STEP = 2'd3
    } lbp_dev_e;
endpackage

// File: rtl/lbp_stack.sv
// Single-bit LIFO with occupancy count.
// Pushes when full and pops when empty are dropped; the caller flags them.
module lbp_stack #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic push_i,
    input  logic pop_i,
    input  logic din_i,
    output logic top_o,
    output logic empty_o,
    output logic full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] mem_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] top_ptr;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign wr_ptr  = PTR_W'(cnt_q);
    assign top_ptr = PTR_W'(cnt_q - 1'b1);
    assign top_o   = empty_o ? 1'b0 : mem_q[top_ptr];

    // Occupancy tracking: clear wins, then push, then pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (push_i && !full_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Entry storage: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (!clr_i && push_i && !full_o) begin
            mem_q[wr_ptr] <= din_i;
        end
    end
endmodule

// File: rtl/lbp_bitmem.sv
// Device bit memory: inputs come from pins, the other three banks are registers.
// Keeps a previous-scan image of all four banks for edge detection.
// Assumes one read and at most one write per cycle.
module lbp_bitmem
    import lbp_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] x_i,
    input  lbp_dev_e         rd_dev_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic             wr_en_i,
    input  lbp_dev_e         wr_dev_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_val_i,
    input  logic             snap_i,
    output logic             cur_o,
    output logic             prev_o,
    output logic [NBITS-1:0] y_o,
    output logic [NBITS-1:0] m_o,
    output logic [NBITS-1:0] s_o
);
    localparam int NBANK = 4;

    logic [NBITS-1:0] bank_q [1:NBANK-1];
    logic [NBITS-1:0] img    [NBANK];
    logic [NBITS-1:0] prev_q [NBANK];

    // One register bank per writable device type.
    for (genvar g = 1; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en_i && (wr_dev_i == lbp_dev_e'(g))) begin
                bank_q[g][wr_idx_i] <= wr_val_i;
            end
        end
    end

    // Assemble the live image of all banks.
    always_comb begin
        img[0] = x_i;
        for (int b = 1; b < NBANK; b++) img[b] = bank_q[b];
    end

    // Previous-scan image, captured at the end of each scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) prev_q[b] <= '0;
        end else if (snap_i) begin
            for (int b = 0; b < NBANK; b++) prev_q[b] <= img[b];
        end
    end

    assign cur_o  = img[rd_dev_i][rd_idx_i];
    assign prev_o = prev_q[rd_dev_i][rd_idx_i];
    assign y_o    = bank_q[1];
    assign m_o    = bank_q[2];
    assign s_o    = bank_q[3];
endmodule

// File: rtl/lbp_core.sv
// Ladder instruction-list boolean processor, top level.
// Accepts one instruction per cycle (always ready) and updates the accumulator,
// both stacks, the device memory and the error flags on the same clock edge.
// Assumes the opcode field holds a defined code.
module lbp_core
    import lbp_pkg::*;
#(
    parameter int NBITS     = 8,
    parameter int BR_DEPTH  = 8,
    parameter int BLK_DEPTH = 16,
    parameter int ANB_MAX   = 8,
    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [4:0]       in_op_i,
    input  logic [1:0]       in_dev_i,
    input  logic [IDX_W-1:0] in_idx_i,
    input  logic [NBITS-1:0] x_i,
    output logic [NBITS-1:0] y_o,
    output logic [NBITS-1:0] m_o,
    output logic [NBITS-1:0] s_o,
    output logic             acc_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int ANB_W = $clog2(ANB_MAX + 2);

    lbp_op_e    op;
    lbp_dev_e   dev;
    logic       accept;
    logic       acc_q, acc_d;
    logic       prog_q, prog_d;
    logic       scan_new_q;
    logic [ANB_W-1:0] anb_q, anb_d;
    logic       ovf_q, unf_q, done_q;
    logic       ovf_set, unf_set;
    logic       cur_bit, prev_bit, rise, fall, opnd;
    logic       blk_push, blk_pop, blk_top, blk_empty, blk_full;
    logic       br_push, br_pop, br_top, br_empty, br_full;
    logic       wr_en, snap, stk_clr;

    assign op         = lbp_op_e'(in_op_i);
    assign dev        = lbp_dev_e'(in_dev_i);
    assign in_ready_o = 1'b1;
    assign accept     = in_valid_i;

    lbp_bitmem #(.NBITS(NBITS)) mem_i (
        .clk(clk), .rst_n(rst_n), .x_i(x_i),
        .rd_dev_i(dev), .rd_idx_i(in_idx_i),
        .wr_en_i(wr_en), .wr_dev_i(dev), .wr_idx_i(in_idx_i), .wr_val_i(acc_q),
        .snap_i(snap), .cur_o(cur_bit), .prev_o(prev_bit),
        .y_o(y_o), .m_o(m_o), .s_o(s_o)
    );

    lbp_stack #(.DEPTH(BLK_DEPTH)) blk_i (
        .clk(clk), .rst_n(rst_n), .clr_i(stk_clr), .push_i(blk_push),
        .pop_i(blk_pop), .din_i(acc_q), .top_o(blk_top),
        .empty_o(blk_empty), .full_o(blk_full)
    );

    lbp_stack #(.DEPTH(BR_DEPTH)) br_i (
        .clk(clk), .rst_n(rst_n), .clr_i(stk_clr), .push_i(br_push),
        .pop_i(br_pop), .din_i(acc_q), .top_o(br_top),
        .empty_o(br_empty), .full_o(br_full)
    );

    assign rise = cur_bit & ~prev_bit;
    assign fall = ~cur_bit & prev_bit;

    // Operand value selected by the contact flavour.
    always_comb begin
        unique case (op)
            OP_LDI, OP_ANI, OP_ORI:    opnd = ~cur_bit;
            OP_LDP, OP_ANDP, OP_ORP:   opnd = rise;
            OP_LDF, OP_ANDF, OP_ORF:   opnd = fall;
            default:                   opnd = cur_bit;
        endcase
    end

    // Instruction decode: next accumulator, stack controls and error events.
    always_comb begin
        acc_d    = acc_q;
        prog_d   = prog_q;
        anb_d    = anb_q;
        blk_push = 1'b0;
        blk_pop  = 1'b0;
        br_push  = 1'b0;
        br_pop   = 1'b0;
        wr_en    = 1'b0;
        snap     = 1'b0;
        stk_clr  = 1'b0;
        ovf_set  = 1'b0;
        unf_set  = 1'b0;
        if (accept) begin
            anb_d = '0;
            unique case (op)
                OP_LD, OP_LDI, OP_LDP, OP_LDF: begin
                    acc_d  = opnd;
                    prog_d = 1'b1;
                    if (prog_q) begin
                        blk_push = 1'b1;
                        ovf_set  = blk_full;
                    end
                end
                OP_AND, OP_ANI, OP_ANDP, OP_ANDF: begin
                    acc_d  = acc_q & opnd;
                    prog_d = 1'b1;
                end
                OP_OR, OP_ORI, OP_ORP, OP_ORF: begin
                    acc_d  = acc_q | opnd;
                    prog_d = 1'b1;
                end
                OP_ANB, OP_ORB: begin
                    if (blk_empty) begin
                        unf_set = 1'b1;
                    end else begin
                        blk_pop = 1'b1;
                        acc_d   = (op == OP_ANB) ? (acc_q & blk_top) : (acc_q | blk_top);
                    end
                    if (op == OP_ANB) begin
                        anb_d   = (anb_q > ANB_W'(ANB_MAX)) ? anb_q : anb_q + 1'b1;
                        if (anb_q >= ANB_W'(ANB_MAX)) ovf_set = 1'b1;
                    end
                end
                OP_MPS: begin
                    br_push = 1'b1;
                    ovf_set = br_full;
                end
                OP_MRD, OP_MPP: begin
                    if (br_empty) begin
                        unf_set = 1'b1;
                    end else begin
                        acc_d  = br_top;
                        br_pop = (op == OP_MPP);
                        prog_d = 1'b1;
                    end
                end
                OP_OUT: begin
                    wr_en  = (dev != DEV_IN);
                    prog_d = 1'b0;
                end
                OP_INV:  acc_d = ~acc_q;
                OP_END: begin
                    snap    = 1'b1;
                    stk_clr = 1'b1;
                    prog_d  = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Architectural state and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= 1'b0;
            prog_q     <= 1'b0;
            anb_q      <= '0;
            scan_new_q <= 1'b1;
            done_q     <= 1'b0;
            ovf_q      <= 1'b0;
            unf_q      <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            prog_q <= prog_d;
            anb_q  <= anb_d;
            done_q <= accept && (op == OP_END);
            if (accept) scan_new_q <= (op == OP_END);
            ovf_q  <= ovf_set | (ovf_q & ~(accept & scan_new_q));
            unf_q  <= unf_set | (unf_q & ~(accept & scan_new_q));
        end
    end

    assign acc_o  = acc_q;
    assign done_o = done_q;
    assign ovf_o  = ovf_q;
    assign unf_o  = unf_q;
endmodule

// File: rtl/lbp_core_sva.sv
// Property checker for lbp_core, attached through bind.
// Assumes a synchronous active-low reset.
module lbp_core_sva
    import lbp_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid_i,
    input logic [4:0]       in_op_i,
    input logic [1:0]       in_dev_i,
    input logic [IDX_W-1:0] in_idx_i,
    input logic [NBITS-1:0] y_o,
    input logic             acc_o,
    input logic             done_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic             br_full,
    input logic             br_empty,
    input logic             scan_new_q
);
    a_r11_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(in_valid_i && in_op_i == OP_END));

    a_r6_branch_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_op_i == OP_MPS && br_full) |=> ovf_o);

    a_r10_read_empty_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_op_i == OP_MRD && br_empty) |=> unf_o);

    a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !(in_valid_i && scan_new_q)) |=> unf_o);

    a_r8_coil_writes_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_op_i == OP_OUT && in_dev_i == DEV_OUT)
        |=> (y_o[$past(in_idx_i)] == $past(acc_o)));

    a_r9_inverse_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_op_i == OP_INV) |=> (acc_o != $past(acc_o)));
endmodule

bind lbp_core lbp_core_sva #(.NBITS(NBITS)) sva_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_op_i(in_op_i),
    .in_dev_i(in_dev_i), .in_idx_i(in_idx_i), .y_o(y_o), .acc_o(acc_o),
    .done_o(done_o), .ovf_o(ovf_o), .unf_o(unf_o), .br_full(br_full),
    .br_empty(br_empty), .scan_new_q(scan_new_q)
);

// File: tb/lbp_core_tb_top.sv
`timescale 1ns/1ps
module lbp_core_tb_top;
    import lbp_pkg::*;

    localparam int NBITS = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [4:0]       in_op = '0;
    logic [1:0]       in_dev = '0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [NBITS-1:0] x = '0;
    logic [NBITS-1:0] y, m, s;
    logic             acc, done, ovf, unf;
    int               n_chk = 0;
    int               n_bad = 0;

    always #2 clk = ~clk;

    lbp_core #(.NBITS(NBITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_op_i(in_op), .in_dev_i(in_dev), .in_idx_i(in_idx), .x_i(x),
        .y_o(y), .m_o(m), .s_o(s), .acc_o(acc), .done_o(done),
        .ovf_o(ovf), .unf_o(unf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one instruction; returns just after the accepting edge.
    task automatic issue(lbp_op_e op, lbp_dev_e dv = DEV_IN, int idx = 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_dev   = dv;
        in_idx   = IDX_W'(idx);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 acc", acc, 0);
        chk("R12 y/m/s", {y, m, s}, 0);
        chk("R12 flags", {done, ovf, unf}, 0);
    endtask

    task automatic t_logic();
        x = 8'b0000_0101;                       // x0=1 x1=0 x2=1 x3=0
        issue(OP_LD, DEV_IN, 0); issue(OP_OR, DEV_IN, 1);
        issue(OP_LD, DEV_IN, 2); issue(OP_ORI, DEV_IN, 3);
        issue(OP_ANB);
        chk("R4 ANB true", acc, 1);
        issue(OP_OUT, DEV_OUT, 0);
        chk("R8 coil Y0", y[0], 1);
        issue(OP_LD, DEV_IN, 1); issue(OP_ANI, DEV_IN, 0);
        chk("R2 ANI", acc, 0);
        issue(OP_OR, DEV_IN, 2);
        chk("R2 OR", acc, 1);
        issue(OP_AND, DEV_IN, 3);
        chk("R2 AND", acc, 0);
        issue(OP_LD, DEV_IN, 1); issue(OP_LD, DEV_IN, 0); issue(OP_AND, DEV_IN, 2);
        issue(OP_ORB);
        chk("R4 ORB", acc, 1);
        issue(OP_OUT, DEV_OUT, 1);
        chk("R8 coil Y1", y[1:0], 2'b11);
        issue(OP_LD, DEV_IN, 1); issue(OP_LD, DEV_IN, 0); issue(OP_ANB);
        chk("R1 push on load, R4 ANB false", acc, 0);
        issue(OP_LDI, DEV_IN, 1);
        chk("R1 LDI", acc, 1);
        issue(OP_INV);
        chk("R9 INV", acc, 0);
        issue(OP_INV);
        issue(OP_OUT, DEV_STEP, 2);
        chk("R8 coil S2", s, 8'h04);
        issue(OP_OUT, DEV_IN, 0);
        chk("R8 coil to input ignored", {y, m, s}, {8'h03, 8'h00, 8'h04});
        issue(OP_END);
        chk("R11 done pulse", done, 1);
        @(posedge clk); #1;
        chk("R11 done one cycle", done, 0);
    endtask

    task automatic t_underflow();
        issue(OP_LD, DEV_IN, 0);
        issue(OP_ORB);
        chk("R10 ORB empty sets unf", unf, 1);
        chk("R10 acc kept", acc, 1);
        issue(OP_LD, DEV_IN, 1);
        chk("R10 sticky", unf, 1);
        issue(OP_END);
        chk("R10 kept through end", unf, 1);
        issue(OP_LD, DEV_IN, 0);
        chk("R10 cleared at scan start", unf, 0);
        issue(OP_END);
    endtask

    task automatic t_branch();
        issue(OP_LD, DEV_IN, 0); issue(OP_MPS);
        issue(OP_AND, DEV_IN, 1); issue(OP_OUT, DEV_INT, 0);
        issue(OP_MRD);
        chk("R5 MRD", acc, 1);
        issue(OP_ANI, DEV_IN, 1); issue(OP_OUT, DEV_INT, 1);
        issue(OP_INV);
        issue(OP_MPP);
        chk("R5 MPP", acc, 1);
        issue(OP_OUT, DEV_INT, 2);
        chk("R5 internal relays", m, 8'b110);
        issue(OP_MRD);
        chk("R5 MPP removed entry", unf, 1);
        issue(OP_END);
        issue(OP_LD, DEV_IN, 0); issue(OP_MPS); issue(OP_END);
        issue(OP_MRD);
        chk("R11 end empties branch stack", unf, 1);
        issue(OP_END);
    endtask

    task automatic t_br_overflow();
        for (int i = 0; i < 8; i++) issue(OP_MPS);
        chk("R6 eight stores legal", ovf, 0);
        issue(OP_MPS);
        chk("R6 ninth store overflows", ovf, 1);
        issue(OP_END);
    endtask

    task automatic t_anb_limit();
        for (int i = 0; i < 10; i++) issue(OP_LD, DEV_IN, 0);
        for (int i = 0; i < 8; i++) issue(OP_ANB);
        chk("R7 eight block-series legal", {ovf, unf}, 2'b00);
        issue(OP_ANB);
        chk("R7 ninth block-series overflows", ovf, 1);
        issue(OP_END);
    endtask

    task automatic t_edges();
        x = 8'h00; issue(OP_END);
        x = 8'h01;
        issue(OP_LDP, DEV_IN, 0); issue(OP_OUT, DEV_OUT, 2);
        issue(OP_LDF, DEV_IN, 0); issue(OP_OUT, DEV_OUT, 3);
        chk("R3 rise seen, fall not", y[3:2], 2'b01);
        issue(OP_END);
        x = 8'h00;
        issue(OP_LDP, DEV_IN, 0); issue(OP_OUT, DEV_OUT, 2);
        issue(OP_LDF, DEV_IN, 0); issue(OP_OUT, DEV_OUT, 3);
        chk("R3 fall seen, rise not", y[3:2], 2'b10);
        issue(OP_LDI, DEV_IN, 1); issue(OP_ANDF, DEV_IN, 0);
        chk("R3 ANDF", acc, 1);
        issue(OP_LD, DEV_IN, 1); issue(OP_ORF, DEV_IN, 0);
        chk("R3 ORF", acc, 1);
        issue(OP_LD, DEV_IN, 1); issue(OP_ORP, DEV_IN, 0);
        chk("R3 ORP no edge", acc, 0);
        issue(OP_END);
        issue(OP_LDF, DEV_IN, 0);
        chk("R3 no change gives 0", acc, 0);
        issue(OP_END);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_logic();
        t_underflow();
        t_branch();
        t_br_overflow();
        t_anb_limit();
        t_edges();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule